// File: doc/BRIEF.md
# Stack-Windowed Register File

This block is the operand register file of a 32-bit three-address core. It has two combinational read ports and one write port. Each port names a register with an 8-bit operand number. The block translates that number to a physical location in three steps. Low numbers go to a small bank of special registers. The middle quarter goes straight to 64 global registers. The upper half goes to 128 local registers, and there the operand is first rotated by an offset held in the stack-pointer global. The local bank therefore acts as a cache for stack frames that slides as the stack pointer moves. With a zero offset it is a plain fixed bank.

The same port pair also evaluates stack-bound checks. When a check is enabled, the two read values are compared as signed numbers under a 3-bit condition code. A false condition raises a trap request for that cycle and stops the write port from updating storage. Spilling and filling frames to memory, trap handling and decode all happen outside this block.

Top module: `winreg_file`

## Requirements
- R1: Operand numbers 0x40 to 0x7F address global registers 0 to 63 directly. A value written to one of them is returned by a later read of the same number on either port.
- R2: With a stack-pointer offset of zero, operand 0x80+k addresses local register k for k = 0 to 127.
- R3: For an operand 0x80+k, the physical local index is (k + sp[8:2]) mod 128. Here sp is the value of global register 1 (operand 0x41), and the sum wraps past 127 back to 0.
- R4: A write to operand 0x41 changes the translation only from the next clock cycle on. Reads and the write in the same cycle as the update still use the old offset.
- R5: When wr_en is high and a read port resolves to the same physical register as the write port, that port returns wr_data in the same cycle (write-first).
- R6: Operands 0x00 to 0x03 are four implemented special registers that can be read and written. Operands 0x04 to 0x3F always read as zero, and writes to them have no effect.
- R7: With chk_en high, rd_a_data is compared with rd_b_data as signed values under chk_cond: 0 greater, 1 greater-or-equal, 2 less, 3 less-or-equal, 4 equal, 5 not-equal. trap_req is high in that cycle exactly when the condition is false. Codes 6 and 7 never trap.
- R8: In a cycle with trap_req high, the write port does not update any register.
- R9: trap_req is low whenever chk_en is low. trap_cond equals chk_cond while trap_req is high and is 0 otherwise.
- R10: After reset, every special, global and local register reads as zero, so the stack-pointer offset is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_num | input | 8 | Operand number for read port A |
| rd_b_num | input | 8 | Operand number for read port B |
| wr_en | input | 1 | Write request |
| wr_num | input | 8 | Operand number for the write port |
| wr_data | input | 32 | Write value |
| chk_en | input | 1 | Enable the assertion compare of A against B |
| chk_cond | input | 3 | Condition that must hold (R7 encoding) |
| rd_a_data | output | 32 | Read port A value |
| rd_b_data | output | 32 | Read port B value |
| trap_req | output | 1 | Check failed in this cycle |
| trap_cond | output | 3 | Failing condition code, zero when no trap |

## Verification
On every cycle, the assertions check four things. Local operands land inside the local window. Forwarded reads return the write value. A trap only appears with a check enabled and reports its code. The stack pointer does not move when no write to it is committed. Other behaviour needs a state history and only the directed scenarios can show it. This covers the wrapped relocation arithmetic, the one-cycle delay of a new offset, values surviving across offset changes, the ignored special numbers, and the signed outcome of each condition code.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_SPEC = 2'd1,
    RK_GPR  = 2'd2
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [7:0] idx;
  } phys_ref_t;

  localparam logic [2:0] CC_GT = 3'd0;
  localparam logic [2:0] CC_GE = 3'd1;
  localparam logic [2:0] CC_LT = 3'd2;
  localparam logic [2:0] CC_LE = 3'd3;
  localparam logic [2:0] CC_EQ = 3'd4;
  localparam logic [2:0] CC_NE = 3'd5;

  function automatic logic same_loc(phys_ref_t x, phys_ref_t y);
    return (x.kind != RK_NONE) && (x.kind == y.kind) && (x.idx == y.idx);
  endfunction

endpackage

// File: rtl/winreg_xlate.sv
module winreg_xlate
  import winreg_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_GLOBAL = 64,
  parameter int NUM_LOCAL  = 128,
  parameter int SPEC_COUNT = 4,
  parameter int SP_LSB     = 2
) (
  input  logic [7:0]        op,
  input  logic [DATA_W-1:0] sp,
  output phys_ref_t         ref_o
);
  localparam int LOC_W = $clog2(NUM_LOCAL);
  localparam int GLB_W = $clog2(NUM_GLOBAL);

  function automatic phys_ref_t map_operand(logic [7:0] num, logic [LOC_W-1:0] offset);
    phys_ref_t r;
    logic [LOC_W-1:0] rot;
    r.kind = RK_NONE;
    r.idx  = '0;
    rot    = num[LOC_W-1:0] + offset;
    if (num[7]) begin
      r.kind = RK_GPR;
      r.idx  = 8'(NUM_GLOBAL) + 8'(rot);
    end else if (num[6]) begin
      r.kind = RK_GPR;
      r.idx  = 8'(num[GLB_W-1:0]);
    end else if (32'(num) < SPEC_COUNT) begin
      r.kind = RK_SPEC;
      r.idx  = num;
    end
    return r;
  endfunction

  logic [LOC_W-1:0] offset;
  assign offset = sp[SP_LSB +: LOC_W];
  assign ref_o  = map_operand(op, offset);

endmodule

// File: rtl/winreg_store.sv
module winreg_store
  import winreg_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_GLOBAL = 64,
  parameter int NUM_LOCAL  = 128,
  parameter int SPEC_COUNT = 4,
  parameter int SP_REG     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phys_ref_t         ref_a,
  input  phys_ref_t         ref_b,
  input  logic              we,
  input  phys_ref_t         ref_w,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] raw_a,
  output logic [DATA_W-1:0] raw_b,
  output logic [DATA_W-1:0] sp_out
);
  localparam int NUM_PHYS = NUM_GLOBAL + NUM_LOCAL;

  logic [DATA_W-1:0] gpr  [NUM_PHYS];
  logic [DATA_W-1:0] spec [SPEC_COUNT];

  function automatic logic [DATA_W-1:0] fetch(phys_ref_t r);
    logic [DATA_W-1:0] v;
    v = '0;
    if (r.kind == RK_GPR && 32'(r.idx) < NUM_PHYS) v = gpr[r.idx];
    else if (r.kind == RK_SPEC && 32'(r.idx) < SPEC_COUNT) v = spec[r.idx[$clog2(SPEC_COUNT)-1:0]];
    return v;
  endfunction

  assign raw_a  = fetch(ref_a);
  assign raw_b  = fetch(ref_b);
  assign sp_out = gpr[SP_REG];

  generate
    for (genvar g = 0; g < NUM_PHYS; g++) begin : g_gpr
      always_ff @(posedge clk) begin
        if (!rst_n) gpr[g] <= '0;
        else if (we && ref_w.kind == RK_GPR && 32'(ref_w.idx) == g) gpr[g] <= wdata;
      end
    end
    for (genvar s = 0; s < SPEC_COUNT; s++) begin : g_spec
      always_ff @(posedge clk) begin
        if (!rst_n) spec[s] <= '0;
        else if (we && ref_w.kind == RK_SPEC && 32'(ref_w.idx) == s) spec[s] <= wdata;
      end
    end
  endgenerate

  logic sp_written;
  assign sp_written = we && ref_w.kind == RK_GPR && 32'(ref_w.idx) == SP_REG;

  a_r4_sp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !sp_written |=> $stable(sp_out));
  a_r6_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_a.kind == RK_NONE) |-> (raw_a == '0));

endmodule

// File: rtl/winreg_check.sv
module winreg_check
  import winreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              en,
  input  logic [2:0]        cc,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              trap,
  output logic [2:0]        trap_cc
);
  function automatic logic cond_holds(logic [2:0] c, logic signed [DATA_W-1:0] x,
                                      logic signed [DATA_W-1:0] y);
    logic lt, eq;
    lt = x < y;
    eq = x == y;
    case (c)
      CC_GT:   return !lt && !eq;
      CC_GE:   return !lt;
      CC_LT:   return lt;
      CC_LE:   return lt || eq;
      CC_EQ:   return eq;
      CC_NE:   return !eq;
      default: return 1'b1;
    endcase
  endfunction

  assign trap    = en && !cond_holds(cc, a, b);
  assign trap_cc = trap ? cc : 3'd0;

endmodule

// File: rtl/winreg_file.sv
module winreg_file
  import winreg_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_GLOBAL = 64,
  parameter int NUM_LOCAL  = 128,
  parameter int SPEC_COUNT = 4,
  parameter int SP_LSB     = 2,
  parameter int SP_REG     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        rd_a_num,
  input  logic [7:0]        rd_b_num,
  input  logic              wr_en,
  input  logic [7:0]        wr_num,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              chk_en,
  input  logic [2:0]        chk_cond,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data,
  output logic              trap_req,
  output logic [2:0]        trap_cond
);
  localparam int NPORT = 3;

  logic [7:0]        ops  [NPORT];
  phys_ref_t         refs [NPORT];
  logic [DATA_W-1:0] sp_val, raw_a, raw_b;
  logic              wr_commit, fwd_a, fwd_b;

  assign ops[0] = rd_a_num;
  assign ops[1] = rd_b_num;
  assign ops[2] = wr_num;

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_xl
      winreg_xlate #(
        .DATA_W(DATA_W), .NUM_GLOBAL(NUM_GLOBAL), .NUM_LOCAL(NUM_LOCAL),
        .SPEC_COUNT(SPEC_COUNT), .SP_LSB(SP_LSB)
      ) u_xl (
        .op(ops[p]), .sp(sp_val), .ref_o(refs[p])
      );
    end
  endgenerate

  winreg_store #(
    .DATA_W(DATA_W), .NUM_GLOBAL(NUM_GLOBAL), .NUM_LOCAL(NUM_LOCAL),
    .SPEC_COUNT(SPEC_COUNT), .SP_REG(SP_REG)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .ref_a(refs[0]), .ref_b(refs[1]),
    .we(wr_commit), .ref_w(refs[2]), .wdata(wr_data),
    .raw_a(raw_a), .raw_b(raw_b), .sp_out(sp_val)
  );

  // Write-first forwarding keyed on the request, matched on physical location
  assign fwd_a     = wr_en && same_loc(refs[2], refs[0]);
  assign fwd_b     = wr_en && same_loc(refs[2], refs[1]);
  assign rd_a_data = fwd_a ? wr_data : raw_a;
  assign rd_b_data = fwd_b ? wr_data : raw_b;

  winreg_check #(.DATA_W(DATA_W)) u_chk (
    .en(chk_en), .cc(chk_cond), .a(rd_a_data), .b(rd_b_data),
    .trap(trap_req), .trap_cc(trap_cond)
  );

  assign wr_commit = wr_en && !trap_req;

  a_r3_local_window: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_num[7] |-> (refs[0].kind == RK_GPR && 32'(refs[0].idx) >= NUM_GLOBAL
                     && 32'(refs[0].idx) < NUM_GLOBAL + NUM_LOCAL));
  a_r5_forward_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_a_num == wr_num && refs[0].kind != RK_NONE) |-> (rd_a_data == wr_data));
  a_r8_trap_keeps_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && wr_num == 8'h40 + 8'(SP_REG)) |=> $stable(sp_val));
  a_r9_trap_needs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (chk_en && trap_cond == chk_cond));

endmodule

// File: tb/tb_winreg_file.sv
`timescale 1ns/1ps
module tb_winreg_file;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  rd_a_num = 0, rd_b_num = 0, wr_num = 0;
  logic        wr_en = 0, chk_en = 0;
  logic [31:0] wr_data = 0;
  logic [2:0]  chk_cond = 0;
  logic [31:0] rd_a_data, rd_b_data;
  logic        trap_req;
  logic [2:0]  trap_cond;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  winreg_file dut (
    .clk(clk), .rst_n(rst_n), .rd_a_num(rd_a_num), .rd_b_num(rd_b_num),
    .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
    .chk_en(chk_en), .chk_cond(chk_cond), .rd_a_data(rd_a_data),
    .rd_b_data(rd_b_data), .trap_req(trap_req), .trap_cond(trap_cond)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] n, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_num = n; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] n, output logic [31:0] v);
    rd_a_num = n; #1; v = rd_a_data;
  endtask

  // sp value that yields local offset o
  function automatic logic [31:0] sp_for(int o);
    return 32'(o * 4);
  endfunction

  function automatic bit want_trap(int c, int a, int b);
    case (c)
      0: return !(a > b);
      1: return !(a >= b);
      2: return !(a < b);
      3: return !(a <= b);
      4: return !(a == b);
      5: return !(a != b);
      default: return 0;
    endcase
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h41, v); check("R10 sp after reset", v, 0);
    rd(8'h80, v); check("R10 local after reset", v, 0);
    rd(8'h7F, v); check("R10 global after reset", v, 0);
    rd(8'h01, v); check("R10 special after reset", v, 0);
  endtask

  task automatic t_global;
    logic [31:0] v;
    wr(8'h45, 32'hA5A5_0001);
    rd(8'h45, v); check("R1 global read A", v, 32'hA5A5_0001);
    rd_b_num = 8'h45; #1; check("R1 global read B", rd_b_data, 32'hA5A5_0001);
  endtask

  task automatic t_local;
    logic [31:0] v;
    wr(8'h80, 32'h1111_0000);
    wr(8'h90, 32'h2222_0000);
    rd(8'h80, v); check("R2 local 0 fixed", v, 32'h1111_0000);
    wr(8'h41, sp_for(16));
    rd(8'h80, v); check("R3 offset 16 reads local 16", v, 32'h2222_0000);
    wr(8'h41, sp_for(120));
    wr(8'h8A, 32'h3333_0002);            // (10+120) mod 128 = 2
    wr(8'h41, 0);
    rd(8'h82, v); check("R3 wraparound lands at local 2", v, 32'h3333_0002);
  endtask

  task automatic t_sp_delay;
    logic [31:0] v;
    @(negedge clk);
    wr_en = 1; wr_num = 8'h41; wr_data = sp_for(16);
    rd_a_num = 8'h80; #1;
    check("R4 same cycle uses old offset", rd_a_data, 32'h1111_0000);
    @(negedge clk); wr_en = 0;
    rd(8'h80, v); check("R4 next cycle uses new offset", v, 32'h2222_0000);
    wr(8'h41, 0);
  endtask

  task automatic t_bypass;
    @(negedge clk);
    wr_en = 1; wr_num = 8'h50; wr_data = 32'hBEEF_0050;
    rd_a_num = 8'h50; rd_b_num = 8'h51; #1;
    check("R5 forward on port A", rd_a_data, 32'hBEEF_0050);
    check("R5 no forward on other reg", rd_b_data, 0);
    wr_num = 8'h85; wr_data = 32'hBEEF_0085; rd_b_num = 8'h85; #1;
    check("R5 forward on local via port B", rd_b_data, 32'hBEEF_0085);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic t_special;
    logic [31:0] v;
    wr(8'h02, 32'h5EC0_0002);
    rd(8'h02, v); check("R6 special 2 stores", v, 32'h5EC0_0002);
    wr(8'h20, 32'hDEAD_0020);
    rd(8'h20, v); check("R6 unimplemented reads zero", v, 0);
    rd(8'h00, v); check("R6 special 0 untouched", v, 0);
  endtask

  task automatic t_conds;
    int av = -5, bv = 3;
    wr(8'h42, 32'(av));
    wr(8'h43, 32'(bv));
    wr(8'h46, 32'(bv));
    @(negedge clk);
    rd_a_num = 8'h42; rd_b_num = 8'h43; chk_en = 0; chk_cond = 0; #1;
    check("R9 no trap without chk_en", {31'b0, trap_req}, 0);
    for (int c = 0; c < 8; c++) begin
      chk_en = 1; chk_cond = 3'(c); #1;
      check($sformatf("R7 signed cc=%0d (-5 vs 3)", c), {31'b0, trap_req}, {31'b0, want_trap(c, av, bv)});
      check($sformatf("R9 trap_cond cc=%0d", c), {29'b0, trap_cond},
            want_trap(c, av, bv) ? 32'(c) : 0);
    end
    rd_a_num = 8'h43; rd_b_num = 8'h46;
    for (int c = 0; c < 6; c++) begin
      chk_cond = 3'(c); #1;
      check($sformatf("R7 equal operands cc=%0d", c), {31'b0, trap_req}, {31'b0, want_trap(c, bv, bv)});
    end
    chk_en = 0;
  endtask

  task automatic t_block;
    logic [31:0] v;
    @(negedge clk);
    rd_a_num = 8'h42; rd_b_num = 8'h43; chk_en = 1; chk_cond = 3'd0; // -5 > 3 false
    wr_en = 1; wr_num = 8'h44; wr_data = 32'hFFFF_0044;
    #1; check("R8 trap raised", {31'b0, trap_req}, 1);
    @(negedge clk); wr_en = 0; chk_en = 0;
    rd(8'h44, v); check("R8 trapped write dropped", v, 0);
    @(negedge clk);
    chk_en = 1; chk_cond = 3'd0; wr_en = 1; wr_num = 8'h41; wr_data = sp_for(16);
    @(negedge clk); wr_en = 0; chk_en = 0;
    rd(8'h41, v); check("R8 trapped sp write dropped", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_global();
    t_local();
    t_sp_delay();
    t_bypass();
    t_special();
    t_conds();
    t_block();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule